// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block guards a system against software that stops making progress. It counts ticks from the system counter and compares them against a programmed period. If a full period passes without a keepalive, it raises a warning level (stage 0), which is normally wired to an interrupt. It then starts a second period of the same length. If that period also passes with no keepalive, it raises a reset level (stage 1) for the reset controller.

Software reaches the block through a simple valid/write/address/data port that selects one of two address frames. Any write to the refresh frame is a keepalive. The control frame holds four registers:

- an enable and status register;
- the period register, split into a low and a high word;
- a read-only identification word.

Because two expiries are needed before a reset, a whole timeout of T seconds is set by programming half of T times the counter frequency. A keepalive that arrives in the same clock cycle as an expiry is never lost: the keepalive wins.

Top module: `wdog_dual_stage`

## Requirements
- R1: With the block enabled and a period N ≥ 1 loaded, stage 0 rises after exactly N tick cycles with no refresh and stays low before that.
- R2: Once stage 0 is high, a further N tick cycles with no refresh raise stage 1. Stage 1 then stays high until block reset, even if the block is disabled.
- R3: Any write to the refresh frame (bus_frame = 1, any address) clears stage 0 and restarts the count from the full period.
- R4: When a refresh write and an expiring tick fall in the same cycle, the refresh wins. Stage 0 ends low, stage 1 does not rise, and a full new period begins.
- R5: Bit 0 of the control register (control offset 0x00) enables the block. While it is clear, the count holds its value, stage 0 is cleared one cycle after the bit falls, and no stage rises.
- R6: Writing the period low word (offset 0x08, bits 31:0) or high word (offset 0x0C, bits 15:0, present only when the architecture version is 1 or more) updates the period and reloads the count with the new value, as a refresh does. Both words read back.
- R7: The control register reads enable at bit 0, stage 0 at bit 1 and stage 1 at bit 2, with the other bits zero.
- R8: The identification word (offset 0x10) reads the 4-bit architecture version at bits 19:16 and the 11-bit implementer code at bits 10:0, with the other bits zero.
- R9: Reads of unmapped control offsets and of the refresh frame return zero. Writes to unmapped control offsets change no state and do not refresh.
- R10: A period of zero expires on every tick, so stage 0 rises on the first tick and stage 1 on the second.
- R11: After reset, both stages are low, the block is disabled and the period is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse for each system counter increment |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | 0 = control frame, 1 = refresh frame |
| bus_addr | input | 8 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| stage0_o | output | 1 | Warning level (first expiry) |
| stage1_o | output | 1 | Reset level (second expiry) |

## Verification
Wrong internal state shows up at the ports in three ways:

- A miscounted period shifts the cycle in which stage 0 rises. The bench sweeps several periods and checks the level one tick before and exactly at the expected tick.
- A lost refresh in the coincidence cycle appears as a stage 0 pulse, or as a premature stage 1, at the very next edge.
- A corrupted hold while disabled moves the expiry point by the number of ticks that leaked through.

Register decode faults show up at once on read-back of the control, period and identification words, and of unmapped offsets.

// File: rtl/wdog_pkg.sv
// Shared constants for the two-stage watchdog: data width, address width,
// control frame offsets and the rule that sets the period width.
package wdog_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PER_LO = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PER_HI = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_IDENT  = 8'h10;

    // Period width as a function of the architecture version.
    function automatic int period_width(input int ver);
        return (ver >= 1) ? 48 : 32;
    endfunction
endpackage

// File: rtl/wdog_regs.sv
// Register decode for the watchdog.
// Holds the enable bit and the period, and produces a reload pulse with its
// reload value for the timer. Reads are combinational in the strobe cycle.
// Assumes single-cycle bus accesses and a word-aligned bus_addr.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          ARCH_VER  = 1,
    parameter logic [10:0] IMPL_CODE = 11'h35B,
    parameter int          PER_W     = period_width(ARCH_VER)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_frame,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stage0,
    input  logic              stage1,
    output logic              enable_o,
    output logic [PER_W-1:0]  period_o,
    output logic              reload_o,
    output logic [PER_W-1:0]  reload_val_o
);
    localparam int HI_W = PER_W - 32;

    logic        ctl_wr, ctl_rd;
    logic        wr_ctrl, wr_lo, wr_hi, wr_refresh;
    logic        en_q;
    logic [31:0] lo_q;
    logic [31:0] lo_next;
    logic [31:0] hi_rd;
    logic        hi_mapped;

    // Strobe decode for each frame.
    always_comb begin
        ctl_wr     = bus_valid && bus_write && !bus_frame;
        ctl_rd     = bus_valid && !bus_write && !bus_frame;
        wr_refresh = bus_valid && bus_write && bus_frame;
        wr_ctrl    = ctl_wr && (bus_addr == OFS_CTRL);
        wr_lo      = ctl_wr && (bus_addr == OFS_PER_LO);
        wr_hi      = ctl_wr && (bus_addr == OFS_PER_HI) && hi_mapped;
        lo_next    = wr_lo ? bus_wdata : lo_q;
    end

    // Enable bit and low period word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            lo_q <= '0;
        end else begin
            if (wr_ctrl) en_q <= bus_wdata[0];
            if (wr_lo)   lo_q <= bus_wdata;
        end
    end

    // High period word, present only for wide periods.
    generate
        if (HI_W > 0) begin : g_hi
            logic [HI_W-1:0] hi_q;
            logic [HI_W-1:0] hi_next;
            always_comb hi_next = wr_hi ? bus_wdata[HI_W-1:0] : hi_q;
            // Store the high period word.
            always_ff @(posedge clk) begin
                if (!rst_n) hi_q <= '0;
                else if (wr_hi) hi_q <= bus_wdata[HI_W-1:0];
            end
            assign hi_mapped    = 1'b1;
            assign hi_rd        = 32'(hi_q);
            assign period_o     = {hi_q, lo_q};
            assign reload_val_o = {hi_next, lo_next};
        end else begin : g_no_hi
            assign hi_mapped    = 1'b0;
            assign hi_rd        = '0;
            assign period_o     = lo_q;
            assign reload_val_o = lo_next;
        end
    endgenerate

    assign enable_o = en_q;
    assign reload_o = wr_refresh || wr_lo || wr_hi;

    // Read mux: unmapped offsets and the refresh frame read as zero.
    always_comb begin
        bus_rdata = '0;
        if (ctl_rd) begin
            case (bus_addr)
                OFS_CTRL:   bus_rdata = {29'b0, stage1, stage0, en_q};
                OFS_PER_LO: bus_rdata = lo_q;
                OFS_PER_HI: bus_rdata = hi_rd;
                OFS_IDENT:  bus_rdata = {12'b0, 4'(ARCH_VER), 5'b0, IMPL_CODE};
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R6
    per_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !bus_frame && bus_addr == OFS_PER_LO)
        |=> period_o[31:0] == $past(bus_wdata));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_addr != OFS_CTRL && bus_addr != OFS_PER_LO && bus_addr != OFS_PER_HI)
        |=> ($stable(period_o) && $stable(enable_o)));

    // R9
    refresh_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_frame) |-> bus_rdata == '0);
endmodule

// File: rtl/wdog_timer.sv
// Period counter and stage sequencer.
// Counts tick pulses down from the period. On expiry it raises stage 0, or
// stage 1 if stage 0 is already high, and reloads the count.
// A reload request always beats an expiry in the same cycle.
// Assumes tick is a single-cycle pulse.
module wdog_timer #(
    parameter int PER_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic [PER_W-1:0] period,
    input  logic             reload,
    input  logic [PER_W-1:0] reload_val,
    output logic             stage0_o,
    output logic             stage1_o
);
    logic [PER_W-1:0] remain_q;
    logic             stage0_q, stage1_q;
    logic             expire;

    // An expiry is a tick that finds the count at one or below.
    always_comb expire = enable && tick && (remain_q <= PER_W'(1));

    // Count, reload and stage sequencing; reload has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            stage0_q <= 1'b0;
            stage1_q <= 1'b0;
        end else if (reload) begin
            remain_q <= reload_val;
            stage0_q <= 1'b0;
        end else if (!enable) begin
            stage0_q <= 1'b0;
        end else if (expire) begin
            remain_q <= period;
            if (stage0_q) stage1_q <= 1'b1;
            else          stage0_q <= 1'b1;
        end else if (tick) begin
            remain_q <= remain_q - PER_W'(1);
        end
    end

    assign stage0_o = stage0_q;
    assign stage1_o = stage1_q;

    // R2
    stage1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage1_q |=> stage1_q);

    // R2
    stage1_after_stage0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage1_q) |-> $past(stage0_q));

    // R4
    reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (!stage0_q && !$rose(stage1_q)));

    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !reload) |=> ($stable(remain_q) && !stage0_q && !$rose(stage1_q)));
endmodule

// File: rtl/wdog_dual_stage.sv
// Top of the two-stage watchdog: register decode plus period timer.
// Stage outputs are registered levels. Read data is combinational.
module wdog_dual_stage
    import wdog_pkg::*;
#(
    parameter int          ARCH_VER  = 1,
    parameter logic [10:0] IMPL_CODE = 11'h35B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_frame,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              stage0_o,
    output logic              stage1_o
);
    localparam int PER_W = period_width(ARCH_VER);

    logic             enable;
    logic             reload;
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] reload_val;

    wdog_regs #(
        .ARCH_VER (ARCH_VER),
        .IMPL_CODE(IMPL_CODE),
        .PER_W    (PER_W)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_frame   (bus_frame),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .stage0      (stage0_o),
        .stage1      (stage1_o),
        .enable_o    (enable),
        .period_o    (period),
        .reload_o    (reload),
        .reload_val_o(reload_val)
    );

    wdog_timer #(
        .PER_W(PER_W)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .enable    (enable),
        .period    (period),
        .reload    (reload),
        .reload_val(reload_val),
        .stage0_o  (stage0_o),
        .stage1_o  (stage1_o)
    );
endmodule

// File: tb/test_wdog_dual_stage.sv
// Self-checking bench: period sweep, refresh races, enable hold and decode.
module test_wdog_dual_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_frame = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        stage0_o, stage1_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    localparam logic [10:0] IMPL = 11'h35B;

    wdog_dual_stage #(.ARCH_VER(1), .IMPL_CODE(IMPL)) i_wdog_dual_stage (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_frame(bus_frame),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stage0_o(stage0_o), .stage1_o(stage1_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic frame, input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_frame = frame;
        bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_frame = 1'b0;
    endtask

    task automatic rd(input logic frame, input logic [7:0] addr, output logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_frame = frame; bus_addr = addr;
        #1 data = bus_rdata;
        bus_valid = 1'b0; bus_frame = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic tick_refresh();
        @(negedge clk);
        tick = 1'b1; bus_valid = 1'b1; bus_write = 1'b1; bus_frame = 1'b1; bus_addr = 8'h00;
        @(negedge clk);
        tick = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_frame = 1'b0;
    endtask

    task automatic start(input logic [31:0] per);
        do_reset();
        wr(1'b0, 8'h00, 32'h1);
        wr(1'b0, 8'h08, per);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();
        // R11 reset state
        chk("R11 stage0", 64'(stage0_o), 0);
        chk("R11 stage1", 64'(stage1_o), 0);
        rd(1'b0, 8'h00, d); chk("R11 ctrl", 64'(d), 0);
        rd(1'b0, 8'h08, d); chk("R11 period", 64'(d), 0);

        // R8 identification fields
        rd(1'b0, 8'h10, d); chk("R8 ident", 64'(d), 64'((32'd1 << 16) | 32'(IMPL)));

        // R1/R2 sweep over periods
        for (int n = 1; n <= 6; n++) begin
            start(32'(n));
            ticks(n - 1); chk("R1 before expiry", 64'(stage0_o), 0);
            ticks(1);     chk("R1 at expiry", 64'(stage0_o), 1);
            chk("R2 not yet", 64'(stage1_o), 0);
            ticks(n - 1); chk("R2 before second", 64'(stage1_o), 0);
            ticks(1);     chk("R2 at second", 64'(stage1_o), 1);
        end
        // R7 status bits, then R2 stickiness through disable
        rd(1'b0, 8'h00, d); chk("R7 ctrl all set", 64'(d), 64'h7);
        wr(1'b0, 8'h00, 32'h0); @(negedge clk);
        rd(1'b0, 8'h00, d); chk("R7 ctrl stage1 only", 64'(d), 64'h4);
        chk("R2 sticky when disabled", 64'(stage1_o), 1);

        // R10 zero period
        start(32'h0);
        ticks(1); chk("R10 stage0", 64'(stage0_o), 1);
        ticks(1); chk("R10 stage1", 64'(stage1_o), 1);

        // R3 refresh frame write restarts and clears stage 0
        start(32'd4);
        ticks(4); chk("R3 expired", 64'(stage0_o), 1);
        wr(1'b1, 8'h24, 32'hDEAD); chk("R3 cleared", 64'(stage0_o), 0);
        ticks(3); chk("R3 restarted", 64'(stage0_o), 0);
        ticks(1); chk("R3 full period", 64'(stage0_o), 1);

        // R4 refresh coinciding with first expiry
        start(32'd4);
        ticks(3); tick_refresh();
        chk("R4 no stage0", 64'(stage0_o), 0);
        ticks(3); chk("R4 new period", 64'(stage0_o), 0);
        ticks(1); chk("R4 then expires", 64'(stage0_o), 1);
        // R4 refresh coinciding with second expiry
        ticks(3); tick_refresh();
        chk("R4 no stage1", 64'(stage1_o), 0);
        chk("R4 stage0 cleared", 64'(stage0_o), 0);

        // R5 disable holds the count
        start(32'd5);
        ticks(2);
        wr(1'b0, 8'h00, 32'h0);
        ticks(10); chk("R5 no expiry when disabled", 64'(stage0_o), 0);
        wr(1'b0, 8'h00, 32'h1);
        ticks(2); chk("R5 count held", 64'(stage0_o), 0);
        ticks(1); chk("R5 resumes", 64'(stage0_o), 1);
        wr(1'b0, 8'h00, 32'h0); @(negedge clk);
        chk("R5 disable clears stage0", 64'(stage0_o), 0);

        // R6 period write acts as refresh
        start(32'd4);
        ticks(3);
        wr(1'b0, 8'h08, 32'd4);
        ticks(3); chk("R6 reloaded", 64'(stage0_o), 0);
        ticks(1); chk("R6 expiry", 64'(stage0_o), 1);
        wr(1'b0, 8'h0C, 32'h1);
        chk("R6 high write refreshes", 64'(stage0_o), 0);
        rd(1'b0, 8'h0C, d); chk("R6 high readback", 64'(d), 1);
        rd(1'b0, 8'h08, d); chk("R6 low readback", 64'(d), 4);
        ticks(20); chk("R6 wide period", 64'(stage0_o), 0);

        // R9 unmapped write does not refresh, unmapped/refresh reads zero
        start(32'd3);
        ticks(2);
        wr(1'b0, 8'h14, 32'hFFFF_FFFF);
        ticks(1); chk("R9 no refresh", 64'(stage0_o), 1);
        rd(1'b0, 8'h08, d); chk("R9 period intact", 64'(d), 3);
        rd(1'b0, 8'h14, d); chk("R9 unmapped read", 64'(d), 0);
        rd(1'b1, 8'h08, d); chk("R9 refresh frame read", 64'(d), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule